// File: doc/BRIEF.md
# Add/Subtract Unit with Flags

This block is the integer add/subtract path of a processor execute stage. Each cycle it takes a first register operand, a second operand, an operation code, the incoming carry flag and a flag-update request. It returns the 32-bit result, the four condition flags (negative, zero, carry, overflow), a flag write strobe and an error bit. The second operand is either a value already prepared by the shifter stage or a 12-bit unsigned immediate. Instruction decode, condition evaluation, the shifter and the register file sit outside the block.

Every operation runs on one adder that computes A + B + cin. Subtraction inverts one operand and sets the carry-in. Reverse subtraction swaps the operands before that inversion. Subtract-with-carry uses the incoming carry flag as the carry-in, so a clear carry acts as a borrow. All outputs are registered, and each result appears one clock after its inputs are sampled.

Top module: `asu_addsub`

## Requirements
- R1: Operation code 3'b000 (add) yields first operand plus second operand, modulo 2^32, one clock after the inputs are sampled.
- R2: Operation code 3'b001 (add with carry) yields first operand plus second operand plus the incoming carry bit.
- R3: Operation code 3'b010 (subtract) yields first operand minus second operand.
- R4: Operation code 3'b011 (subtract with carry) yields first operand minus second operand, minus one more when the incoming carry is 0 and with no extra decrement when it is 1.
- R5: Operation code 3'b100 (reverse subtract) yields second operand minus first operand.
- R6: When the immediate select is high and the code is add or subtract, the 12-bit immediate, zero-extended to 32 bits, replaces the flexible second operand.
- R7: When the immediate select is high with add with carry, subtract with carry or reverse subtract, the immediate is ignored and the flexible operand is used. The error output is 1 for that result and 0 for every other result.
- R8: On a flag write, N equals result bit 31, and Z is 1 exactly when all 32 result bits are 0.
- R9: On a flag write, C is the adder carry-out. For subtract, subtract with carry and reverse subtract, C is 1 exactly when no borrow occurred.
- R10: On a flag write, V is 1 exactly when the operation overflowed as signed two's-complement arithmetic.
- R11: When the flag-update request is 1, the flag write strobe is 1 one clock later. When the request is 0, the strobe is 0 and all four flag outputs keep their previous values.
- R12: While reset is low, the result, flags, strobe and error output are all 0.
- R13: The unused codes 3'b101 to 3'b111 compute a plain add with carry-in 0, accept the immediate and never raise the error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code |
| rn_i | input | 32 | First register operand |
| flex_i | input | 32 | Prepared second operand from the shifter |
| imm_i | input | 12 | Unsigned 12-bit immediate |
| imm_sel_i | input | 1 | Use the immediate as second operand |
| carry_i | input | 1 | Incoming carry flag |
| setflags_i | input | 1 | Request a flag update |
| result_o | output | 32 | Registered result |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry / no-borrow flag |
| flag_v_o | output | 1 | Signed overflow flag |
| flag_we_o | output | 1 | Flag write strobe |
| imm_err_o | output | 1 | Immediate used with a form that disallows it |

## Verification
The result, the four flags, the strobe and the error bit all come from a single register stage, so each is due at the first rising edge after its inputs are applied. The bench changes inputs on a falling edge and compares on the following falling edge, which is exactly one rising edge later and half a period away from any edge. The flags are compared against a copy kept in the bench. That copy is updated only on cycles that request a flag write, so the hold behaviour is checked on every vector that does not request one.

// File: rtl/asu_pkg.sv
package asu_pkg;

    typedef enum logic [2:0] {
        ASU_ADD = 3'd0,
        ASU_ADC = 3'd1,
        ASU_SUB = 3'd2,
        ASU_SBC = 3'd3,
        ASU_RSB = 3'd4
    } asu_op_e;

endpackage

// File: rtl/asu_operand_sel.sv
module asu_operand_sel
    import asu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 12
) (
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] rn_i,
    input  logic [WIDTH-1:0] flex_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             imm_sel_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] add_a_o,
    output logic [WIDTH-1:0] add_b_o,
    output logic             add_cin_o,
    output logic             imm_err_o
);

    localparam int PAD_W = WIDTH - IMM_W;

    logic             imm_forbidden;
    logic [WIDTH-1:0] imm_ext;
    logic [WIDTH-1:0] op2;

    always_comb begin
        imm_forbidden = (op_i == ASU_ADC) || (op_i == ASU_SBC) || (op_i == ASU_RSB);
        imm_err_o     = imm_sel_i && imm_forbidden;
        imm_ext       = {{PAD_W{1'b0}}, imm_i};
        op2           = (imm_sel_i && !imm_forbidden) ? imm_ext : flex_i;

        add_a_o   = rn_i;
        add_b_o   = op2;
        add_cin_o = 1'b0;
        case (op_i)
            ASU_ADC: begin
                add_cin_o = carry_i;
            end
            ASU_SUB: begin
                add_b_o   = ~op2;
                add_cin_o = 1'b1;
            end
            ASU_SBC: begin
                add_b_o   = ~op2;
                add_cin_o = carry_i;
            end
            ASU_RSB: begin
                add_a_o   = op2;
                add_b_o   = ~rn_i;
                add_cin_o = 1'b1;
            end
            default: begin
                add_cin_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/asu_adder.sv
module asu_adder #(
    parameter int WIDTH = 32,
    parameter int CHUNK = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int NCHUNK = WIDTH / CHUNK;

    logic [NCHUNK:0] carry;

    assign carry[0] = cin_i;

    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        logic [CHUNK:0] sum_c0;
        logic [CHUNK:0] sum_c1;

        assign sum_c0 = {1'b0, a_i[g*CHUNK +: CHUNK]} + {1'b0, b_i[g*CHUNK +: CHUNK]};
        assign sum_c1 = {1'b0, a_i[g*CHUNK +: CHUNK]} + {1'b0, b_i[g*CHUNK +: CHUNK]}
                        + {{CHUNK{1'b0}}, 1'b1};
        assign sum_o[g*CHUNK +: CHUNK] = carry[g] ? sum_c1[CHUNK-1:0] : sum_c0[CHUNK-1:0];
        assign carry[g+1]              = carry[g] ? sum_c1[CHUNK]     : sum_c0[CHUNK];
    end

    assign cout_o = carry[NCHUNK];
    assign ovf_o  = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);

endmodule

// File: rtl/asu_flags.sv
module asu_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sum_i,
    input  logic             cout_i,
    input  logic             ovf_i,
    output logic             n_o,
    output logic             z_o,
    output logic             c_o,
    output logic             v_o
);

    always_comb begin
        n_o = sum_i[WIDTH-1];
        z_o = (sum_i == '0);
        c_o = cout_i;
        v_o = ovf_i;
    end

endmodule

// File: rtl/asu_addsub.sv
module asu_addsub
    import asu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 12,
    parameter int CHUNK = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] rn_i,
    input  logic [WIDTH-1:0] flex_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             imm_sel_i,
    input  logic             carry_i,
    input  logic             setflags_i,
    output logic [WIDTH-1:0] result_o,
    output logic             flag_n_o,
    output logic             flag_z_o,
    output logic             flag_c_o,
    output logic             flag_v_o,
    output logic             flag_we_o,
    output logic             imm_err_o
);

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             n;
        logic             z;
        logic             c;
        logic             v;
        logic             we;
        logic             err;
    } asu_state_t;

    asu_state_t st_d, st_q;

    logic [WIDTH-1:0] add_a, add_b, sum;
    logic             add_cin, cout, ovf, sel_err;
    logic             fl_n, fl_z, fl_c, fl_v;

    asu_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_sel (
        .op_i      (op_i),
        .rn_i      (rn_i),
        .flex_i    (flex_i),
        .imm_i     (imm_i),
        .imm_sel_i (imm_sel_i),
        .carry_i   (carry_i),
        .add_a_o   (add_a),
        .add_b_o   (add_b),
        .add_cin_o (add_cin),
        .imm_err_o (sel_err)
    );

    asu_adder #(.WIDTH(WIDTH), .CHUNK(CHUNK)) u_add (
        .a_i    (add_a),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sum_o  (sum),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    asu_flags #(.WIDTH(WIDTH)) u_flags (
        .sum_i  (sum),
        .cout_i (cout),
        .ovf_i  (ovf),
        .n_o    (fl_n),
        .z_o    (fl_z),
        .c_o    (fl_c),
        .v_o    (fl_v)
    );

    always_comb begin
        st_d        = st_q;
        st_d.result = sum;
        st_d.err    = sel_err;
        st_d.we     = setflags_i;
        if (setflags_i) begin
            st_d.n = fl_n;
            st_d.z = fl_z;
            st_d.c = fl_c;
            st_d.v = fl_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o  = st_q.result;
    assign flag_n_o  = st_q.n;
    assign flag_z_o  = st_q.z;
    assign flag_c_o  = st_q.c;
    assign flag_v_o  = st_q.v;
    assign flag_we_o = st_q.we;
    assign imm_err_o = st_q.err;

    a_r11_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !setflags_i |=> (!flag_we_o && $stable({flag_n_o, flag_z_o, flag_c_o, flag_v_o})));

    a_r11_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        setflags_i |=> flag_we_o);

    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (flag_z_o == (result_o == '0)));

    a_r8_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> (flag_n_o == result_o[WIDTH-1]));

    a_r7_imm_err: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_sel_i && (op_i == ASU_ADC || op_i == ASU_SBC || op_i == ASU_RSB)) |=> imm_err_o);

    a_r7_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        !imm_sel_i |=> !imm_err_o);

    a_r6_imm_add: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_sel_i && op_i == ASU_ADD) |=> (result_o == $past(rn_i) + WIDTH'($past(imm_i))));

    a_r3_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_sel_i && op_i == ASU_SUB) |=> (result_o == $past(rn_i) - $past(flex_i)));

endmodule

// File: tb/tb_asu_addsub.sv
module tb_asu_addsub;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_i;
    logic [31:0] rn_i, flex_i;
    logic [11:0] imm_i;
    logic        imm_sel_i, carry_i, setflags_i;
    logic [31:0] result_o;
    logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o, flag_we_o, imm_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    asu_addsub dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .rn_i(rn_i), .flex_i(flex_i),
        .imm_i(imm_i), .imm_sel_i(imm_sel_i), .carry_i(carry_i), .setflags_i(setflags_i),
        .result_o(result_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
        .flag_c_o(flag_c_o), .flag_v_o(flag_v_o), .flag_we_o(flag_we_o),
        .imm_err_o(imm_err_o)
    );

    logic [31:0] vals [8];
    logic [3:0]  exp_flags;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [36:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic c);
        logic [32:0] s;
        logic [31:0] r;
        logic        cf, vf, bw;
        bw = !c;
        case (op)
            3'd1: begin
                s = {1'b0, a} + {1'b0, b} + {32'd0, c};
                r = s[31:0]; cf = s[32];
                vf = (a[31] == b[31]) && (r[31] != a[31]);
            end
            3'd2: begin
                r = a - b; cf = (a >= b);
                vf = (a[31] != b[31]) && (r[31] != a[31]);
            end
            3'd3: begin
                r = a - b - {31'd0, bw};
                cf = ({1'b0, a} >= ({1'b0, b} + {32'd0, bw}));
                vf = (a[31] != b[31]) && (r[31] != a[31]);
            end
            3'd4: begin
                r = b - a; cf = (b >= a);
                vf = (b[31] != a[31]) && (r[31] != b[31]);
            end
            default: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[31:0]; cf = s[32];
                vf = (a[31] == b[31]) && (r[31] != a[31]);
            end
        endcase
        return {r, r[31], (r == 32'd0), cf, vf, 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
        vals[4] = 32'hFFFF_FFFF; vals[5] = 32'hFFFF_FFFE;
        vals[6] = 32'h1234_5678; vals[7] = 32'h0000_0FFF;
        rst_n = 1'b0; op_i = '0; rn_i = 32'h5; flex_i = 32'h7; imm_i = '0;
        imm_sel_i = 1'b0; carry_i = 1'b1; setflags_i = 1'b1;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 result", {32'd0, result_o}, 64'd0);
        check("R12 flags/strobe/err",
              {58'd0, flag_n_o, flag_z_o, flag_c_o, flag_v_o, flag_we_o, imm_err_o}, 64'd0);
        exp_flags = 4'b0000;
        rst_n = 1'b1;
        setflags_i = 1'b0;
        @(negedge clk);
        check("R11 hold after reset",
              {59'd0, flag_n_o, flag_z_o, flag_c_o, flag_v_o, flag_we_o}, 64'd0);

        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic        c, isel, legal, err, sf;
                        logic [31:0] op2;
                        logic [36:0] m;
                        string       rq;
                        c    = k[0];
                        isel = k[1];
                        sf   = (((op * 64 + i * 8 + j + k) % 3) != 0);
                        op_i = 3'(op); rn_i = vals[i]; flex_i = vals[j];
                        imm_i = 12'(vals[(j + 3) % 8] ^ 32'h5A5);
                        imm_sel_i = isel; carry_i = c; setflags_i = sf;
                        legal = !(op == 1 || op == 3 || op == 4);
                        err   = isel && !legal;
                        op2   = (isel && legal) ? {20'd0, imm_i} : flex_i;
                        m     = model(3'(op), rn_i, op2, c);
                        @(negedge clk);
                        case (op)
                            0: rq = isel ? "R1 R6 add result" : "R1 add result";
                            1: rq = isel ? "R2 R7 adc result" : "R2 adc result";
                            2: rq = isel ? "R3 R6 sub result" : "R3 sub result";
                            3: rq = isel ? "R4 R7 sbc result" : "R4 sbc result";
                            4: rq = isel ? "R5 R7 rsb result" : "R5 rsb result";
                            default: rq = "R13 unused-code result";
                        endcase
                        check(rq, {32'd0, result_o}, {32'd0, m[36:5]});
                        if (sf) exp_flags = m[4:1];
                        check(sf ? "R8 R9 R10 flags" : "R11 flags held",
                              {60'd0, flag_n_o, flag_z_o, flag_c_o, flag_v_o},
                              {60'd0, exp_flags});
                        check("R11 strobe", {63'd0, flag_we_o}, {63'd0, sf});
                        check(op > 4 ? "R13 no error" : "R7 error", {63'd0, imm_err_o},
                              {63'd0, err});
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule